// File: doc/BRIEF.md
# Block-Lock Write Protection Guard

This unit sits beside the serial protocol engine of a small nonvolatile byte memory and decides, one page commit at a time, whether a nonvolatile write may go ahead. It keeps a one-byte lock control register and an internal write-enable latch. The control register holds a lock-enable bit that ties the external guard pin into the decision, and a two-bit lock level that freezes zero, the top quarter, the top half or all of the data array.

The protocol engine reports four kinds of event: an arm event when a reset sequence has completed, an invalid-write event, a commit request carrying the page start address, byte count and first data byte, and the end of a nonvolatile write cycle. The unit answers each commit with a registered permit flag and shows the control register for readback. A permitted commit to the control register address changes the register when the engine reports that the write cycle has finished. The array size is a parameter: 2048, 8192 or 16384 bytes. The nonvolatile bits are modelled as flops that reset to zero.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset the control register reads 0x00, the write-enable latch reads 0 and the permit flag reads 0.
- R2: The control register keeps only bit 7 (lock enable) and bits 3:2 (lock level); every other bit is stored as 0, so writing 0xFF reads back 0x8C.
- R3: Lock level 0 protects no array byte, 1 protects addresses from 3/4 of the array size upward, 2 protects from 1/2 of the array size upward, and 3 protects the whole array.
- R4: When the guard pin is low and the lock-enable bit is 1 in the commit cycle, a commit to address 0xFFFF is refused; with the lock-enable bit at 0 the pin does not affect control register commits.
- R5: The write-enable latch is cleared on the clock edge after any cycle in which the guard pin is low, the invalid-write event is high, the end-of-write event is high, or a commit is refused; a clear wins over an arm in the same cycle.
- R6: The write-enable latch goes from 0 to 1 only on the edge after a cycle with the arm event high and no clear condition.
- R7: A commit to address 0xFFFF is permitted only with a byte count of exactly 1 and the latch set.
- R8: A commit to any other address is permitted only when the latch is set, the byte count is 1 to 32, the address lies inside the array, and the page lies outside the protected range.
- R9: The permit flag reflects the decision for a commit on the clock edge that samples the commit and holds that value until the next commit.
- R10: The control register takes the masked first byte of a permitted control register commit on the edge after the end-of-write event; without a permitted commit, or before that event, it does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guard_pin_n | input | 1 | External guard pin, low requests hardware locking |
| arm_i | input | 1 | Reset sequence completed, sets the write-enable latch |
| invalid_i | input | 1 | Invalid write seen by the protocol engine |
| commit_i | input | 1 | Page commit request, one cycle |
| commit_addr_i | input | 16 | Start address of the committed page, 0xFFFF for the control register |
| commit_len_i | input | 6 | Number of bytes loaded for the commit |
| commit_byte_i | input | 8 | First loaded data byte |
| nv_done_i | input | 1 | End of the nonvolatile write cycle |
| permit_o | output | 1 | Registered permit flag for the last commit |
| wel_o | output | 1 | Write-enable latch state |
| ctrl_o | output | 8 | Control register readback |

## Verification
The assertions assume that commit requests, arm, invalid-write and end-of-write events are single-cycle strobes from a well-behaved engine, and that the guard pin is a synchronised level. They do not assume that an end-of-write event follows every commit, so the control register property checks only that changes follow an end-of-write event. The random stimulus keeps events independent per cycle, biases commit addresses toward the control address, lock-level borders and out-of-array values, and biases byte counts toward 0, 1, 32 and 33, while directed steps force each ordering the rules name, such as a pin drop in the commit cycle and arm with clear together.

// File: rtl/blk_lock_pkg.sv
// Package: shared constants and types of the block-lock guard.
// Assumes a one-byte control register at the top of a 16-bit address space.
package blk_lock_pkg;
    localparam int          LOCK_EN_BIT = 7;
    localparam int          LVL_HI_BIT  = 3;
    localparam int          LVL_LO_BIT  = 2;
    localparam logic [7:0]  CTRL_KEEP   = 8'h8C;
    localparam logic [15:0] CTRL_ADDR   = 16'hFFFF;

    typedef enum logic [1:0] {
        LOCK_NONE    = 2'b00,
        LOCK_QUARTER = 2'b01,
        LOCK_HALF    = 2'b10,
        LOCK_ALL     = 2'b11
    } lock_lvl_e;
endpackage

// File: rtl/blk_lock_range.sv
// Module: address classifier. Tells whether a commit targets the control
// register and whether a data page commit is legal against the lock level.
// Assumes ARRAY_BYTES is a power of two of at least four pages, so quarter
// borders are page aligned and the page start quarter decides the page.
module blk_lock_range #(
    parameter int ARRAY_BYTES = 8192,
    parameter int PAGE_BYTES  = 32,
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 6
) (
    input  logic [1:0]        lvl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              is_ctrl_o,
    output logic              page_ok_o
);
    import blk_lock_pkg::*;

    localparam int AW = $clog2(ARRAY_BYTES);

    logic       in_array;
    logic [1:0] quarter;
    logic       len_ok;
    logic       locked;
    logic       unused_low;

    // Upper address bits must be zero for an address inside the array.
    generate
        if (AW < ADDR_W) begin : g_upper
            assign in_array = (addr_i[ADDR_W-1:AW] == '0);
        end else begin : g_full
            assign in_array = 1'b1;
        end
    endgenerate

    assign quarter    = addr_i[AW-1 -: 2];
    assign unused_low = ^addr_i[AW-3:0];
    assign is_ctrl_o  = (addr_i == CTRL_ADDR);
    assign len_ok     = (len_i != '0) && (len_i <= LEN_W'(PAGE_BYTES));

    // Map the lock level onto the quarter of the page start.
    always_comb begin
        case (lock_lvl_e'(lvl_i))
            LOCK_NONE:    locked = 1'b0;
            LOCK_QUARTER: locked = (quarter == 2'b11);
            LOCK_HALF:    locked = quarter[1];
            default:      locked = 1'b1;
        endcase
    end

    assign page_ok_o = in_array && len_ok && !locked && !is_ctrl_o;

    // R3: a full lock never lets a page through.
    always_comb begin
        if (lvl_i == 2'b11) begin
            a_r3_full_lock: assert (!page_ok_o);
        end
    end
endmodule

// File: rtl/blk_lock_wel.sv
// Module: internal write-enable latch. Set by a completed reset sequence,
// cleared by every clear condition, clears taking priority.
// Assumes all events are single-cycle strobes and the pin is synchronised.
module blk_lock_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic arm_i,
    input  logic invalid_i,
    input  logic done_i,
    input  logic refuse_i,
    output logic wel_o
);
    logic wel_q;
    logic clear;

    assign clear = !pin_n_i || invalid_i || done_i || refuse_i;

    // Latch update: any clear beats an arm in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (clear) begin
            wel_q <= 1'b0;
        end else if (arm_i) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

    a_r5_pin_holds_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_n_i |=> !wel_q);

    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !wel_q);

    a_r6_set_by_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(arm_i));
endmodule

// File: rtl/blk_lock_ctrl_reg.sv
// Module: lock control register with a pending-write stage. A granted
// commit parks the masked byte; the end of the write cycle applies it.
// Assumes the engine raises done_i once per nonvolatile write cycle.
module blk_lock_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit_i,
    input  logic       grant_i,
    input  logic [7:0] byte_i,
    input  logic       done_i,
    output logic [7:0] ctrl_o
);
    import blk_lock_pkg::*;

    logic [7:0] ctrl_q;
    logic [7:0] park_q;
    logic       pend_q;

    // Pending stage: each commit replaces it, the end of a write empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            park_q <= '0;
        end else if (commit_i) begin
            pend_q <= grant_i;
            park_q <= byte_i & CTRL_KEEP;
        end else if (done_i) begin
            pend_q <= 1'b0;
        end
    end

    // Register update: applies the parked byte at the end of the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (done_i && pend_q) begin
            ctrl_q <= park_q;
        end
    end

    assign ctrl_o = ctrl_q;

    a_r10_change_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(ctrl_q));
endmodule

// File: rtl/blk_lock_guard.sv
// Module: top of the block-lock write protection guard. Combines the latch,
// the pin-gated lock enable and the lock level into one permit decision per
// commit, registered at the commit and held until the next one.
// Assumes the serial protocol engine supplies decoded single-cycle events.
module blk_lock_guard #(
    parameter  int ARRAY_BYTES = 8192,
    parameter  int PAGE_BYTES  = 32,
    localparam int LEN_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             guard_pin_n,
    input  logic             arm_i,
    input  logic             invalid_i,
    input  logic             commit_i,
    input  logic [15:0]      commit_addr_i,
    input  logic [LEN_W-1:0] commit_len_i,
    input  logic [7:0]       commit_byte_i,
    input  logic             nv_done_i,
    output logic             permit_o,
    output logic             wel_o,
    output logic [7:0]       ctrl_o
);
    import blk_lock_pkg::*;

    logic is_ctrl;
    logic page_ok;
    logic hw_lock;
    logic ctrl_ok;
    logic permit_d;
    logic permit_q;
    logic wel;
    logic [7:0] ctrl;

    blk_lock_range #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .ADDR_W      (16),
        .LEN_W       (LEN_W)
    ) u_range (
        .lvl_i     (ctrl[LVL_HI_BIT:LVL_LO_BIT]),
        .addr_i    (commit_addr_i),
        .len_i     (commit_len_i),
        .is_ctrl_o (is_ctrl),
        .page_ok_o (page_ok)
    );

    // Decision: pin-gated lock for the register, lock level for pages.
    assign hw_lock  = !guard_pin_n && ctrl[LOCK_EN_BIT];
    assign ctrl_ok  = is_ctrl && !hw_lock && (commit_len_i == LEN_W'(1));
    assign permit_d = wel && (ctrl_ok || page_ok);

    blk_lock_wel u_wel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n_i   (guard_pin_n),
        .arm_i     (arm_i),
        .invalid_i (invalid_i),
        .done_i    (nv_done_i),
        .refuse_i  (commit_i && !permit_d),
        .wel_o     (wel)
    );

    blk_lock_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_i),
        .grant_i  (permit_d && is_ctrl),
        .byte_i   (commit_byte_i),
        .done_i   (nv_done_i),
        .ctrl_o   (ctrl)
    );

    // Permit flag: sampled at each commit, held until the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit_q <= 1'b0;
        end else if (commit_i) begin
            permit_q <= permit_d;
        end
    end

    assign permit_o = permit_q;
    assign wel_o    = wel;
    assign ctrl_o   = ctrl;

    a_r9_permit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(permit_o));

    a_r8_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !wel_o) |=> !permit_o);

    a_r4_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && commit_addr_i == 16'hFFFF && !guard_pin_n && ctrl_o[7]) |=> !permit_o);

    a_r7_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && commit_addr_i == 16'hFFFF && commit_len_i != 6'd1) |=> !permit_o);
endmodule

// File: tb/blk_lock_guard_tb.sv
module blk_lock_guard_tb;
    localparam int ARRAY = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_n = 1'b1;
    logic        arm = 1'b0;
    logic        inv = 1'b0;
    logic        com = 1'b0;
    logic [15:0] addr = '0;
    logic [5:0]  len = '0;
    logic [7:0]  byt = '0;
    logic        done = 1'b0;
    logic        permit;
    logic        wel;
    logic [7:0]  ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_ctrl = '0;
    logic [7:0] m_park = '0;
    logic       m_pend = 1'b0;
    logic       m_wel  = 1'b0;
    logic       m_ok   = 1'b0;

    blk_lock_guard #(.ARRAY_BYTES(ARRAY), .PAGE_BYTES(32)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .guard_pin_n   (pin_n),
        .arm_i         (arm),
        .invalid_i     (inv),
        .commit_i      (com),
        .commit_addr_i (addr),
        .commit_len_i  (len),
        .commit_byte_i (byt),
        .nv_done_i     (done),
        .permit_o      (permit),
        .wel_o         (wel),
        .ctrl_o        (ctrl)
    );

    always #5 clk = ~clk;

    // Expected permit from the requirements (R3, R4, R7, R8).
    function automatic bit f_permit(logic [7:0] c, logic w, logic p,
                                    logic [15:0] a, logic [5:0] n);
        int base;
        bit prot;
        if (!w) return 1'b0;
        if (a == 16'hFFFF) return (n == 6'd1) && !(!p && c[7]);
        if (n == 0 || n > 32 || int'(a) >= ARRAY) return 1'b0;
        base = int'(a) & ~31;
        case (c[3:2])
            2'b00: prot = 1'b0;
            2'b01: prot = base >= (3 * ARRAY) / 4;
            2'b10: prot = base >= ARRAY / 2;
            default: prot = 1'b1;
        endcase
        return !prot;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, advance the model, check after.
    task automatic step(string tag, bit p, bit a_, bit iv, bit c_,
                        logic [15:0] ad, logic [5:0] n, logic [7:0] b, bit d);
        bit ok;
        pin_n = p; arm = a_; inv = iv; com = c_; addr = ad; len = n; byt = b; done = d;
        ok = f_permit(m_ctrl, m_wel, p, ad, n);
        if (d && m_pend) m_ctrl = m_park;
        if (c_) begin
            m_pend = ok && (ad == 16'hFFFF);
            m_park = b & 8'h8C;
            m_ok   = ok;
        end else if (d) begin
            m_pend = 1'b0;
        end
        if (!p || iv || d || (c_ && !ok)) m_wel = 1'b0;
        else if (a_) m_wel = 1'b1;
        @(negedge clk);
        chk(tag, "permit", int'(permit), int'(m_ok));
        chk(tag, "latch", int'(wel), int'(m_wel));
        chk(tag, "ctrl", int'(ctrl), int'(m_ctrl));
    endtask

    task automatic idle(string tag);
        step(tag, 1, 0, 0, 0, 16'h0, 6'd0, 8'h0, 0);
    endtask

    task automatic arm1(string tag);
        step(tag, 1, 1, 0, 0, 16'h0, 6'd0, 8'h0, 0);
    endtask

    task automatic commit(string tag, bit p, logic [15:0] ad, logic [5:0] n, logic [7:0] b);
        step(tag, p, 0, 0, 1, ad, n, b, 0);
    endtask

    task automatic finish_wr(string tag);
        step(tag, 1, 0, 0, 0, 16'h0, 6'd0, 8'h0, 1);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1d5e);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        // R6: latch stays clear without arm, then sets on arm
        idle("R6"); idle("R6");
        arm1("R6");
        // R2 / R10: register write, visible only after end of write
        commit("R2", 1, 16'hFFFF, 6'd1, 8'hFF);
        idle("R10");
        finish_wr("R2");
        // R3: full lock refuses page 0; refusal clears the latch (R5)
        arm1("R3");
        commit("R3", 1, 16'h0000, 6'd32, 8'h00);
        // R7: two bytes to the register address refused
        arm1("R7");
        commit("R7", 1, 16'hFFFF, 6'd2, 8'h04);
        // R10: refused commit plus end of write leaves register unchanged
        finish_wr("R10");
        // R4: lock enable on, pin low in the commit cycle refuses
        arm1("R4");
        commit("R4", 0, 16'hFFFF, 6'd1, 8'h04);
        // move to quarter lock with enable off
        arm1("R10");
        commit("R10", 1, 16'hFFFF, 6'd1, 8'h04);
        finish_wr("R10");
        // R3: quarter border
        arm1("R3");
        commit("R3", 1, 16'h17E0, 6'd32, 8'h11);
        arm1("R3");
        commit("R3", 1, 16'h1800, 6'd1, 8'h11);
        // R4: enable off, pin low does not block register commit
        arm1("R4");
        commit("R4", 0, 16'hFFFF, 6'd1, 8'h88);
        arm1("R4");
        commit("R4", 1, 16'hFFFF, 6'd1, 8'h88);
        finish_wr("R4");
        // R5: clear wins over arm (pin low with arm)
        step("R5", 0, 1, 0, 0, 16'h0, 6'd0, 8'h0, 0);
        step("R5", 1, 1, 1, 0, 16'h0, 6'd0, 8'h0, 0);
        // R8: half lock, lower half permitted; permit held (R9)
        arm1("R8");
        commit("R8", 1, 16'h0FE0, 6'd32, 8'h00);
        idle("R9"); idle("R9");
        arm1("R3");
        commit("R3", 1, 16'h1000, 6'd8, 8'h00);
        // R8: out of array, zero and oversize lengths
        arm1("R8");
        commit("R8", 1, 16'h2000, 6'd1, 8'h00);
        arm1("R8");
        commit("R8", 1, 16'h0020, 6'd0, 8'h00);
        arm1("R8");
        commit("R8", 1, 16'h0040, 6'd33, 8'h00);
        arm1("R8");
        commit("R8", 1, 16'h0040, 6'd1, 8'h00);
        // R5: invalid-write event clears latch
        arm1("R5");
        step("R5", 1, 0, 1, 0, 16'h0, 6'd0, 8'h0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ra;
            logic [5:0]  rn;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 3) ra = 16'hFFFF;
            else if (sel < 5) ra = 16'(($urandom_range(0, 7) * ARRAY) / 8);
            else if (sel < 6) ra = 16'($urandom_range(ARRAY, 16'hFFFE));
            else ra = 16'($urandom_range(0, ARRAY - 1));
            sel = $urandom_range(0, 7);
            case (sel)
                0: rn = 6'd0;
                1, 2: rn = 6'd1;
                3: rn = 6'd32;
                4: rn = 6'd33;
                default: rn = 6'($urandom_range(1, 40));
            endcase
            step("R3/R4/R5/R7/R8/R9/R10",
                 $urandom_range(0, 9) != 0,
                 $urandom_range(0, 3) == 0,
                 $urandom_range(0, 29) == 0,
                 $urandom_range(0, 3) == 0,
                 ra, rn, 8'($urandom),
                 $urandom_range(0, 5) == 0);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule